// File: doc/BRIEF.md
# UART Autobaud Boot Handshake

This block sits on a serial receive line whose bit rate is not known in advance. Out of reset it waits for the host to send a single calibration character. That character is `@` (0x40), framed as one start bit, eight data bits with no parity, and one stop bit. Because 0x40 is sent least significant bit first, the line stays low without a break from the start bit through data bit 5. The block counts that low span in clock cycles. From the span it derives the bit period and a divisor, which is one sixteenth of the bit period. The divisor is published on a port.

Once the calibration character has finished, the block replies on its transmit line at the measured rate. The reply is four 8N1 frames: a fixed header byte, the two divisor bytes, and a zero trailer. After the reply the host may stream boot bytes. Each byte is sampled at mid-bit and handed to the consumer through a one-entry valid/ready stage.

The clear-to-send output tells the host whether it may send. The consumer applies back-pressure by holding `out_ready` low. While a byte waits in the stage, `out_valid` stays high, the data stays frozen, and clear-to-send is low. The host must respect clear-to-send. A byte that completes while the stage is full and not being drained is discarded. The calibration character itself is sent without regard to clear-to-send.

Top module: `uart_autobaud_link`

## Requirements
- R1: After reset, `txd` is 1, `cts` is 0, `out_valid` is 0 and `divisor` is 0.
- R2: The low span of the calibration character is counted in clock cycles, from its falling edge to the next rising edge. The bit period is set to span/7, rounded to nearest. `divisor` is set to span/112, rounded to nearest.
- R3: A low span is discarded, and the block waits for a new falling edge, in two cases: the rounded divisor would be 0, or the count reaches its all-ones limit while the line is still low. In both cases no reply is sent and `divisor` stays 0.
- R4: The reply starts at the middle of the calibration character's stop bit. It is four frames at the measured bit period, each with a 0 start bit, data sent LSB first and a 1 stop bit. The frames are sent in this order: 0xBF, `divisor[7:0]`, `divisor[15:8]`, 0x00.
- R5: `txd` is 1 at all times other than during the reply.
- R6: After the reply, each byte arriving on `rxd` is sampled at mid-bit. It is presented on `out_data` with the first received bit in bit 0.
- R7: `out_ferr` is 1 when the stop bit is sampled as 0. After such a byte, the receiver waits for the line to return high before it looks for the next start bit.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_ferr` hold their values. A transfer takes place on a clock edge where both are 1.
- R9: `cts` is 1 only after the reply has ended and while the output stage is empty.
- R10: A byte that completes while the stage holds an undelivered byte, and `out_ready` is 0, is dropped. The held byte is unchanged.
- R11: Once nonzero, `divisor` keeps its value until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial receive line, idle high, asynchronous |
| txd | output | 1 | Serial transmit line, idle high |
| cts | output | 1 | High when the host may send a byte |
| out_valid | output | 1 | A received byte is held on `out_data` |
| out_ready | input | 1 | Consumer accepts the held byte; low means busy |
| out_data | output | 8 | Received byte |
| out_ferr | output | 1 | Framing error flag for the held byte |
| divisor | output | DIV_W | Measured divisor (bit period / 16) |

## Verification
A wrong span count shows up within one character time as a wrong divisor byte in the reply. It also shows up as a drifting sample point, so bytes received afterwards come out garbled or flagged with framing errors. If the phase sequencing gets stuck, `cts` never rises and `txd` stays idle. A wrongly accepted span shows up the other way: a reply appears after a glitch or an over-long low. A faulty holding stage shows on the very next edge after a byte lands, as data changing under back-pressure or `cts` high while `out_valid` is set.

// File: rtl/ab_pkg.sv
package ab_pkg;
  localparam logic [7:0] REPLY_HEAD = 8'hBF;
  localparam logic [7:0] REPLY_TAIL = 8'h00;
  typedef enum logic [1:0] {PH_CAL, PH_ACK, PH_RUN} phase_t;
endpackage

// File: rtl/ab_calib.sv
module ab_calib #(
  parameter int CNT_W = 20,
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rxd,
  output logic             done,
  output logic [CNT_W-1:0] bit_clks,
  output logic [DIV_W-1:0] divisor
);
  localparam int W1 = CNT_W + 1;
  typedef enum logic [2:0] {C_HIGH, C_FALL, C_MEAS, C_TAIL, C_DONE} cst_t;

  cst_t             st;
  logic [CNT_W-1:0] cnt;
  logic [W1-1:0]    cnt_x, bp_calc, div_calc, tail_calc;

  // rounded span/7 and span/112; the tail wait reaches mid stop bit
  assign cnt_x     = {1'b0, cnt};
  assign bp_calc   = (cnt_x + W1'(3)) / W1'(7);
  assign div_calc  = (cnt_x + W1'(56)) / W1'(112);
  assign tail_calc = (bp_calc << 1) + (bp_calc >> 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= C_HIGH;
      cnt      <= '0;
      done     <= 1'b0;
      bit_clks <= '0;
      divisor  <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        C_HIGH: if (rxd) st <= C_FALL;
        C_FALL: if (!rxd) begin
          cnt <= CNT_W'(1);
          st  <= C_MEAS;
        end
        C_MEAS: begin
          if (!rxd) begin
            if (cnt == {CNT_W{1'b1}}) st <= C_HIGH;
            else cnt <= cnt + 1'b1;
          end else if (div_calc == '0) begin
            st <= C_FALL;
          end else begin
            bit_clks <= CNT_W'(bp_calc);
            divisor  <= DIV_W'(div_calc);
            cnt      <= CNT_W'(tail_calc);
            st       <= C_TAIL;
          end
        end
        C_TAIL: begin
          if (cnt == '0) begin
            done <= 1'b1;
            st   <= C_DONE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= C_DONE;
      endcase
    end
  end
endmodule

// File: rtl/ab_tx.sv
module ab_tx #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [31:0]      frame_bytes,
  input  logic [CNT_W-1:0] bit_clks,
  output logic             txd,
  output logic             done
);
  logic             active;
  logic [1:0]       byte_idx;
  logic [3:0]       bit_idx;
  logic [CNT_W-1:0] timer;
  logic [9:0]       shreg;
  logic [7:0]       next_byte;

  assign next_byte = frame_bytes[{byte_idx + 2'd1, 3'b000} +: 8];
  assign txd       = active ? shreg[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      byte_idx <= '0;
      bit_idx  <= '0;
      timer    <= '0;
      shreg    <= '1;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !active) begin
        active   <= 1'b1;
        byte_idx <= '0;
        bit_idx  <= '0;
        timer    <= bit_clks - 1'b1;
        shreg    <= {1'b1, frame_bytes[7:0], 1'b0};
      end else if (active) begin
        if (timer == '0) begin
          timer <= bit_clks - 1'b1;
          if (bit_idx == 4'd9) begin
            if (byte_idx == 2'd3) begin
              active <= 1'b0;
              done   <= 1'b1;
            end else begin
              byte_idx <= byte_idx + 2'd1;
              bit_idx  <= '0;
              shreg    <= {1'b1, next_byte, 1'b0};
            end
          end else begin
            bit_idx <= bit_idx + 4'd1;
            shreg   <= {1'b1, shreg[9:1]};
          end
        end else begin
          timer <= timer - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ab_rx.sv
module ab_rx #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             rxd,
  input  logic [CNT_W-1:0] bit_clks,
  output logic             byte_valid,
  output logic [7:0]       byte_data,
  output logic             frame_err
);
  typedef enum logic [2:0] {R_HIGH, R_IDLE, R_START, R_DATA, R_STOP} rst_t;

  rst_t             st;
  logic [CNT_W-1:0] timer;
  logic [2:0]       bit_idx;
  logic [7:0]       shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= R_HIGH;
      timer      <= '0;
      bit_idx    <= '0;
      shreg      <= '0;
      byte_valid <= 1'b0;
      byte_data  <= '0;
      frame_err  <= 1'b0;
    end else begin
      byte_valid <= 1'b0;
      unique case (st)
        R_HIGH: if (enable && rxd) st <= R_IDLE;
        R_IDLE: if (!rxd) begin
          timer <= bit_clks >> 1;
          st    <= R_START;
        end
        R_START: begin
          if (timer != '0) begin
            timer <= timer - 1'b1;
          end else if (!rxd) begin
            timer   <= bit_clks - 1'b1;
            bit_idx <= '0;
            st      <= R_DATA;
          end else begin
            st <= R_IDLE;
          end
        end
        R_DATA: begin
          if (timer != '0) begin
            timer <= timer - 1'b1;
          end else begin
            shreg   <= {rxd, shreg[7:1]};
            timer   <= bit_clks - 1'b1;
            bit_idx <= bit_idx + 3'd1;
            if (bit_idx == 3'd7) st <= R_STOP;
          end
        end
        default: begin
          if (timer != '0) begin
            timer <= timer - 1'b1;
          end else begin
            byte_valid <= 1'b1;
            byte_data  <= shreg;
            frame_err  <= !rxd;
            st         <= rxd ? R_IDLE : R_HIGH;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/uart_autobaud_link.sv
module uart_autobaud_link
  import ab_pkg::*;
#(
  parameter int CNT_W = 20,
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rxd,
  output logic             txd,
  output logic             cts,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_ferr,
  output logic [DIV_W-1:0] divisor
);
  logic             rxd_meta, rxd_s;
  logic             cal_done, tx_done, rx_valid, rx_ferr;
  logic [7:0]       rx_data;
  logic [CNT_W-1:0] bit_clks;
  logic [15:0]      div16;
  phase_t           phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxd_meta <= 1'b1;
      rxd_s    <= 1'b1;
    end else begin
      rxd_meta <= rxd;
      rxd_s    <= rxd_meta;
    end
  end

  ab_calib #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_calib (
    .clk(clk), .rst_n(rst_n), .rxd(rxd_s),
    .done(cal_done), .bit_clks(bit_clks), .divisor(divisor)
  );

  assign div16 = 16'(divisor);

  ab_tx #(.CNT_W(CNT_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .start(cal_done),
    .frame_bytes({REPLY_TAIL, div16[15:8], div16[7:0], REPLY_HEAD}),
    .bit_clks(bit_clks), .txd(txd), .done(tx_done)
  );

  ab_rx #(.CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .enable(phase == PH_RUN), .rxd(rxd_s),
    .bit_clks(bit_clks), .byte_valid(rx_valid), .byte_data(rx_data),
    .frame_err(rx_ferr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_CAL;
    end else begin
      unique case (phase)
        PH_CAL:  if (cal_done) phase <= PH_ACK;
        PH_ACK:  if (tx_done) phase <= PH_RUN;
        default: phase <= PH_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_ferr  <= 1'b0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (rx_valid && (!out_valid || out_ready)) begin
        out_valid <= 1'b1;
        out_data  <= rx_data;
        out_ferr  <= rx_ferr;
      end
    end
  end

  assign cts = (phase == PH_RUN) && !out_valid;
endmodule

// File: rtl/uart_autobaud_link_chk.sv
module uart_autobaud_link_chk #(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             txd,
  input logic             cts,
  input logic             out_valid,
  input logic             out_ready,
  input logic [7:0]       out_data,
  input logic             out_ferr,
  input logic [DIV_W-1:0] divisor
);
  AST_TX_IDLE_PRECAL: assert property (@(posedge clk) disable iff (!rst_n)
    (divisor == '0) |-> txd); // R5

  AST_NO_SEND_PRECAL: assert property (@(posedge clk) disable iff (!rst_n)
    (divisor == '0) |-> (!out_valid && !cts)); // R9

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_ferr))); // R8

  AST_CTS_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !cts); // R9

  AST_DIV_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (divisor != '0) |=> $stable(divisor)); // R11
endmodule

bind uart_autobaud_link uart_autobaud_link_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .txd(txd), .cts(cts), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_ferr(out_ferr),
  .divisor(divisor)
);

// File: tb/uart_autobaud_link_bench.sv
module uart_autobaud_link_bench;
  localparam int CNT_W = 14;
  localparam int DIV_W = 16;
  localparam int BP    = 160;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             rxd = 1'b1;
  logic             txd, cts, out_valid, out_ferr;
  logic             out_ready = 1'b1;
  logic [7:0]       out_data;
  logic [DIV_W-1:0] divisor;

  int n_vec = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  uart_autobaud_link #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_uart_autobaud_link (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .txd(txd), .cts(cts),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_ferr(out_ferr), .divisor(divisor)
  );

  // {stop bit, data}; expected out_ferr is the inverse of the stop bit
  localparam logic [8:0] VEC [0:5] = '{9'h155, 9'h100, 9'h1FF, 9'h0A3, 9'h17E, 9'h081};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] d, input logic stop);
    @(negedge clk) rxd = 1'b0;
    repeat (BP) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i];
      repeat (BP) @(negedge clk);
    end
    rxd = stop;
    repeat (BP) @(negedge clk);
    if (!stop) begin
      rxd = 1'b1;
      repeat (BP) @(negedge clk);
    end
  endtask

  task automatic recv_byte(output logic [7:0] d, output logic framed);
    @(negedge clk);
    while (txd !== 1'b0) @(negedge clk);
    repeat (BP / 2) @(negedge clk);
    framed = (txd == 1'b0);
    for (int i = 0; i < 8; i++) begin
      repeat (BP) @(negedge clk);
      d[i] = txd;
    end
    repeat (BP) @(negedge clk);
    framed = framed && (txd == 1'b1);
  endtask

  task automatic quiet_window(input int cycles, input string req);
    int lows = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) lows++;
    end
    check(req, lows, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] ack [0:3];
    logic       fr  [0:3];
    repeat (5) @(negedge clk);
    check("R1 txd", txd, 1);
    check("R1 cts", cts, 0);
    check("R1 out_valid", out_valid, 0);
    check("R1 divisor", divisor, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R3: low longer than the counter range
    rxd = 1'b0;
    repeat (17000) @(negedge clk);
    rxd = 1'b1;
    quiet_window(2000, "R3 overflow no reply");
    check("R3 overflow divisor", divisor, 0);

    // R3: glitch too short for a nonzero divisor
    rxd = 1'b0;
    repeat (40) @(negedge clk);
    rxd = 1'b1;
    quiet_window(2000, "R3 glitch no reply");
    check("R3 glitch divisor", divisor, 0);
    check("R9 cts before reply", cts, 0);

    // R2, R4: calibration at 160 clocks per bit -> divisor 10
    fork
      send_byte(8'h40, 1'b1);
      for (int k = 0; k < 4; k++) recv_byte(ack[k], fr[k]);
    join
    check("R2 divisor", divisor, 10);
    check("R4 head", ack[0], 8'hBF);
    check("R4 div low", ack[1], 8'h0A);
    check("R4 div high", ack[2], 8'h00);
    check("R4 tail", ack[3], 8'h00);
    for (int k = 0; k < 4; k++) check("R4 framing", fr[k], 1);
    repeat (BP) @(negedge clk);
    check("R5 idle after reply", txd, 1);
    check("R9 cts after reply", cts, 1);

    // R6, R7, R8: vector table under back-pressure
    out_ready = 1'b0;
    for (int v = 0; v < 6; v++) begin
      send_byte(VEC[v][7:0], VEC[v][8]);
      check("R6 valid", out_valid, 1);
      check("R6 data", out_data, VEC[v][7:0]);
      check("R7 ferr", out_ferr, !VEC[v][8]);
      check("R9 cts while full", cts, 0);
      repeat (20) @(negedge clk);
      check("R8 held", {out_valid, out_data}, {1'b1, VEC[v][7:0]});
      out_ready = 1'b1;
      @(negedge clk) out_ready = 1'b0;
      check("R8 drained", out_valid, 0);
    end

    // R10: second byte while full is dropped
    send_byte(8'h3C, 1'b1);
    check("R10 first", out_data, 8'h3C);
    send_byte(8'hC3, 1'b1);
    check("R10 held unchanged", {out_valid, out_data}, {1'b1, 8'h3C});
    out_ready = 1'b1;
    @(negedge clk);
    check("R9 cts reopens", cts, 1);
    repeat (2 * BP) @(negedge clk);
    check("R10 dropped", out_valid, 0);
    check("R11 divisor kept", divisor, 10);
    check("R5 idle in run", txd, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule